// File: doc/BRIEF.md
# Multi-Core Interrupt Router with Acknowledge

This block gathers level-sensitive interrupt lines from peripherals and decides, for every CPU of a cluster, which of them may interrupt that CPU. A global register bank holds a per-source enable and a per-source routing bitmap. Each CPU has its own bank, selected by a CPU-id input on the register bus. That bank holds a private mask per source and an acknowledge register. The acknowledge register reports the lowest-numbered source that is currently eligible for the CPU.

Enable and mask bits are never written as bitmasks. Software writes the number of one source to a "set" address or to a "clear" address, so no read-modify-write is needed. Three source numbers are private to each CPU and ignore the global enable and the routing table:
- source 0 comes from a per-CPU doorbell summary input;
- source 1 comes from a per-CPU message summary input;
- source 5 comes from a per-CPU local timer input.

Register writes take effect at the next rising clock edge. Reads are combinational from the address, bank and CPU-id inputs.

Top module: `irt_router`

## Requirements
- R1: After reset every source is globally disabled, every per-CPU mask bit is set, and every routing word reads 0. Every CPU's acknowledge register reads 1023, and every `irq_out` bit is 0, even when lines are high.
- R2: A global write to byte offset 0x30 sets the enable of the source whose number is in `bus_wdata`. A global write to offset 0x34 clears that enable.
- R3: A per-CPU write to offset 0x48 masks the given source for the CPU named by `bus_cpu`. A per-CPU write to offset 0x4C unmasks it. Masks of other CPUs are unchanged.
- R4: A per-CPU read at offset 0x44 returns, in bits [9:0], the lowest-numbered source eligible for that CPU. All other bits read 0.
- R5: The routing word of source n is at global offset 0x100+4n. Bit c of that word routes source n to CPU c. The word is readable and writable in its low NUM_CPU bits.
- R6: A global read at offset 0x00 returns the number of implemented sources in bits [12:2].
- R7: Source 0 follows `ipi_sum[c]` and source 1 follows `msg_sum[c]`, each for CPU c only. Both are gated solely by that CPU's mask.
- R8: Source 5 follows `tmr_line[c]` for CPU c only and is gated solely by that CPU's mask. The enable, the routing word and `src_line[5]` have no effect on it.
- R9: Sources are level-sensitive. A source is pending only while its line is high, and nothing is latched.
- R10: `irq_out[c]` is 1 exactly when CPU c's acknowledge value is not 1023.
- R11: A set or clear write whose data is at or above the source count changes no enable and no mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_bank | input | 1 | 0 selects the global bank, 1 selects the per-CPU bank |
| bus_cpu | input | CPU_W | CPU id that selects the per-CPU bank |
| bus_addr | input | ADDR_W | Byte offset within the selected bank |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| src_line | input | NUM_SRC | Level-sensitive source lines |
| ipi_sum | input | NUM_CPU | Per-CPU doorbell summary, delivered as source 0 |
| msg_sum | input | NUM_CPU | Per-CPU message summary, delivered as source 1 |
| tmr_line | input | NUM_CPU | Per-CPU local timer, delivered as source 5 |
| irq_out | output | NUM_CPU | Interrupt request per CPU |

## Verification
The hardest situation to reach is a write whose data aliases a real source number once its upper bits are dropped. A router that truncates the index would silently enable or mask the wrong source. The stimulus reaches this case in a known state: source 7 is disabled, source 12 is enabled, and each is routed to a different CPU. It then writes 39 to the enable-set address and 44 to the mask-set address, and reads both CPUs' acknowledge values.

The private sources are exercised in the same way. Their global enable and routing word stay zero, and the shared line `src_line[5]` is driven high, so only the per-CPU summary and timer inputs can explain an acknowledge value.

// File: rtl/irt_pkg.sv
package irt_pkg;
   localparam int unsigned ID_W        = 10;
   localparam logic [9:0]  NONE_ID     = 10'h3FF;
   localparam int unsigned DATA_W      = 32;
   // global bank byte offsets
   localparam int unsigned OFS_CTRL    = 'h000;
   localparam int unsigned OFS_EN_SET  = 'h030;
   localparam int unsigned OFS_EN_CLR  = 'h034;
   localparam int unsigned OFS_ROUTE   = 'h100;
   // per-CPU bank byte offsets
   localparam int unsigned OFS_ACK     = 'h044;
   localparam int unsigned OFS_MSK_SET = 'h048;
   localparam int unsigned OFS_MSK_CLR = 'h04C;
   // private per-CPU source numbers
   localparam int unsigned SRC_IPI     = 0;
   localparam int unsigned SRC_MSG     = 1;
   localparam int unsigned SRC_TMR     = 5;
endpackage

// File: rtl/irt_enable_bank.sv
module irt_enable_bank
   import irt_pkg::*;
#(
   parameter int NUM_SRC = 32,
   parameter int ADDR_W  = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [DATA_W-1:0]  wdata,
   output logic [NUM_SRC-1:0] en_q
);
   logic set_stb, clr_stb;
   assign set_stb = wr_en && (addr == ADDR_W'(OFS_EN_SET));
   assign clr_stb = wr_en && (addr == ADDR_W'(OFS_EN_CLR));

   // full-width compare: indices at or above NUM_SRC hit nothing
   for (genvar n = 0; n < NUM_SRC; n++) begin : g_en
      logic hit;
      assign hit = (wdata == DATA_W'(n));
      always_ff @(posedge clk) begin
         if (!rst_n)              en_q[n] <= 1'b0;
         else if (set_stb && hit) en_q[n] <= 1'b1;
         else if (clr_stb && hit) en_q[n] <= 1'b0;
      end
   end
endmodule

// File: rtl/irt_route_table.sv
module irt_route_table
   import irt_pkg::*;
#(
   parameter int NUM_SRC = 32,
   parameter int NUM_CPU = 4,
   parameter int ADDR_W  = 12
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             wr_en,
   input  logic [ADDR_W-1:0]                addr,
   input  logic [DATA_W-1:0]                wdata,
   output logic [NUM_SRC-1:0][NUM_CPU-1:0]  route_q
);
   for (genvar n = 0; n < NUM_SRC; n++) begin : g_word
      logic hit;
      assign hit = (addr == ADDR_W'(OFS_ROUTE + 4 * n));
      always_ff @(posedge clk) begin
         if (!rst_n)            route_q[n] <= '0;
         else if (wr_en && hit) route_q[n] <= wdata[NUM_CPU-1:0];
      end
   end
endmodule

// File: rtl/irt_cpu_port.sv
module irt_cpu_port
   import irt_pkg::*;
#(
   parameter int NUM_SRC = 32,
   parameter int ADDR_W  = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [DATA_W-1:0]  wdata,
   input  logic [NUM_SRC-1:0] src_line,
   input  logic               ipi_in,
   input  logic               msg_in,
   input  logic               tmr_in,
   input  logic [NUM_SRC-1:0] en_q,
   input  logic [NUM_SRC-1:0] route_col,
   output logic [NUM_SRC-1:0] mask_q,
   output logic [ID_W-1:0]    ack_id,
   output logic               irq
);
   logic set_stb, clr_stb;
   logic [NUM_SRC-1:0] elig;

   assign set_stb = wr_en && (addr == ADDR_W'(OFS_MSK_SET));
   assign clr_stb = wr_en && (addr == ADDR_W'(OFS_MSK_CLR));

   for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
      logic hit, lvl, pass;
      assign hit = (wdata == DATA_W'(n));
      always_ff @(posedge clk) begin
         if (!rst_n)              mask_q[n] <= 1'b1;
         else if (set_stb && hit) mask_q[n] <= 1'b1;
         else if (clr_stb && hit) mask_q[n] <= 1'b0;
      end
      // private sources bypass the global enable and the routing table
      if (n == SRC_IPI) begin : g_ipi
         assign lvl  = ipi_in;
         assign pass = 1'b1;
      end else if (n == SRC_MSG) begin : g_msg
         assign lvl  = msg_in;
         assign pass = 1'b1;
      end else if (n == SRC_TMR) begin : g_tmr
         assign lvl  = tmr_in;
         assign pass = 1'b1;
      end else begin : g_glb
         assign lvl  = src_line[n];
         assign pass = en_q[n] & route_col[n];
      end
      assign elig[n] = lvl & pass & ~mask_q[n];
   end

   // lowest number wins: scan downward so the last hit is the smallest
   always_comb begin
      ack_id = NONE_ID;
      for (int n = NUM_SRC - 1; n >= 0; n--)
         if (elig[n]) ack_id = ID_W'(n);
   end

   assign irq = |elig;
endmodule

// File: rtl/irt_router.sv
module irt_router
   import irt_pkg::*;
#(
   parameter  int NUM_SRC = 32,
   parameter  int NUM_CPU = 4,
   parameter  int ADDR_W  = 12,
   localparam int CPU_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_wr,
   input  logic               bus_bank,
   input  logic [CPU_W-1:0]   bus_cpu,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [31:0]        bus_wdata,
   output logic [31:0]        bus_rdata,
   input  logic [NUM_SRC-1:0] src_line,
   input  logic [NUM_CPU-1:0] ipi_sum,
   input  logic [NUM_CPU-1:0] msg_sum,
   input  logic [NUM_CPU-1:0] tmr_line,
   output logic [NUM_CPU-1:0] irq_out
);
   // elaboration-time parameter checks
   if (NUM_SRC < 6 || NUM_SRC > 1023) begin : g_bad_src
      $error("NUM_SRC must lie in 6..1023");
   end
   if (NUM_CPU < 1 || NUM_CPU > 32) begin : g_bad_cpu
      $error("NUM_CPU must lie in 1..32");
   end
   if (OFS_ROUTE + 4 * NUM_SRC > (1 << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too narrow for the routing window");
   end

   logic                            glb_wr;
   logic [NUM_SRC-1:0]              en_q;
   logic [NUM_SRC-1:0][NUM_CPU-1:0] route_q;
   logic [NUM_CPU-1:0][NUM_SRC-1:0] mask_q;
   logic [NUM_CPU-1:0][ID_W-1:0]    ack_all;

   assign glb_wr = bus_wr && !bus_bank;

   irt_enable_bank #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_en (
      .clk(clk), .rst_n(rst_n), .wr_en(glb_wr), .addr(bus_addr),
      .wdata(bus_wdata), .en_q(en_q));

   irt_route_table #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W)) u_rt (
      .clk(clk), .rst_n(rst_n), .wr_en(glb_wr), .addr(bus_addr),
      .wdata(bus_wdata), .route_q(route_q));

   for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
      logic               cpu_wr;
      logic [NUM_SRC-1:0] col;
      assign cpu_wr = bus_wr && bus_bank && (bus_cpu == CPU_W'(c));
      for (genvar n = 0; n < NUM_SRC; n++) begin : g_col
         assign col[n] = route_q[n][c];
      end
      irt_cpu_port #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_port (
         .clk(clk), .rst_n(rst_n), .wr_en(cpu_wr), .addr(bus_addr),
         .wdata(bus_wdata), .src_line(src_line), .ipi_in(ipi_sum[c]),
         .msg_in(msg_sum[c]), .tmr_in(tmr_line[c]), .en_q(en_q),
         .route_col(col), .mask_q(mask_q[c]), .ack_id(ack_all[c]),
         .irq(irq_out[c]));
   end

   always_comb begin
      bus_rdata = '0;
      if (!bus_bank) begin
         if (bus_addr == ADDR_W'(OFS_CTRL))
            bus_rdata[12:2] = 11'(NUM_SRC);
         for (int n = 0; n < NUM_SRC; n++)
            if (bus_addr == ADDR_W'(OFS_ROUTE + 4 * n))
               bus_rdata[NUM_CPU-1:0] = route_q[n];
      end else if (bus_addr == ADDR_W'(OFS_ACK)) begin
         for (int c = 0; c < NUM_CPU; c++)
            if (bus_cpu == CPU_W'(c))
               bus_rdata[ID_W-1:0] = ack_all[c];
      end
   end
endmodule

// File: rtl/irt_router_chk.sv
module irt_router_chk
   import irt_pkg::*;
#(
   parameter int NUM_SRC = 32,
   parameter int NUM_CPU = 4
) (
   input logic                            clk,
   input logic                            rst_n,
   input logic                            bus_wr,
   input logic                            bus_bank,
   input logic [NUM_CPU-1:0]              ipi_sum,
   input logic [NUM_CPU-1:0]              msg_sum,
   input logic [NUM_CPU-1:0]              tmr_line,
   input logic [NUM_CPU-1:0]              irq_out,
   input logic [NUM_SRC-1:0]              en_q,
   input logic [NUM_CPU-1:0][NUM_SRC-1:0] mask_q,
   input logic [NUM_CPU-1:0][ID_W-1:0]    ack_all
);
   logic [NUM_CPU-1:0] ack_busy, priv_ipi, priv_tmr;
   logic               ack_in_range;

   always_comb begin
      ack_in_range = 1'b1;
      for (int c = 0; c < NUM_CPU; c++) begin
         ack_busy[c] = (ack_all[c] != NONE_ID);
         priv_ipi[c] = (ipi_sum[c] & ~mask_q[c][SRC_IPI]) |
                       (msg_sum[c] & ~mask_q[c][SRC_MSG]);
         priv_tmr[c] = tmr_line[c] & ~mask_q[c][SRC_TMR];
         if (ack_all[c] != NONE_ID && int'(ack_all[c]) >= NUM_SRC)
            ack_in_range = 1'b0;
      end
   end

   assert_irq_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (irq_out == '0));

   assert_enable_only_by_global_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && !bus_bank) |=> $stable(en_q));

   assert_mask_only_by_cpu_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && bus_bank) |=> $stable(mask_q));

   assert_ack_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ack_in_range);

   assert_private_summary_delivered_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (priv_ipi & ~irq_out) == '0);

   assert_timer_delivered_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (priv_tmr & ~irq_out) == '0);

   assert_irq_matches_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out == ack_busy);
endmodule

bind irt_router irt_router_chk #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_bank(bus_bank),
   .ipi_sum(ipi_sum), .msg_sum(msg_sum), .tmr_line(tmr_line),
   .irq_out(irq_out), .en_q(en_q), .mask_q(mask_q), .ack_all(ack_all));

// File: tb/irt_router_tb.sv
`timescale 1ns/1ps
module irt_router_tb;
   localparam int NS = 32;
   localparam int NC = 4;
   localparam int AW = 12;

   typedef enum logic [2:0] {OP_WR, OP_RD, OP_SRC, OP_LOC, OP_IRQ} op_t;
   typedef struct packed {
      op_t         op;
      logic        bank;
      logic [1:0]  cpu;
      logic [11:0] addr;
      logic [31:0] data;
      logic [31:0] exp;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 54;
   // LOC data: [3:0] doorbell summary, [7:4] message summary, [11:8] timer
   localparam vec_t VECS [NV] = '{
      '{OP_RD , 1'b0, 2'd0, 12'h000, 32'd0     , 32'h80 , 4'd6 },  // R6 source count
      '{OP_RD , 1'b1, 2'd0, 12'h044, 32'd0     , 32'h3FF, 4'd1 },  // R1
      '{OP_RD , 1'b0, 2'd0, 12'h11C, 32'd0     , 32'h0  , 4'd1 },  // R1 routing zero
      '{OP_SRC, 1'b0, 2'd0, 12'h000, 32'h80    , 32'h0  , 4'd0 },
      '{OP_WR , 1'b0, 2'd0, 12'h11C, 32'd5     , 32'h0  , 4'd0 },
      '{OP_RD , 1'b0, 2'd0, 12'h11C, 32'd0     , 32'h5  , 4'd5 },  // R5
      '{OP_WR , 1'b0, 2'd0, 12'h030, 32'd7     , 32'h0  , 4'd0 },
      '{OP_RD , 1'b1, 2'd0, 12'h044, 32'd0     , 32'h3FF, 4'd1 },  // R1 masks set
      '{OP_IRQ, 1'b0, 2'd0, 12'h000, 32'd0     , 32'h0  , 4'd1 },  // R1
      '{OP_WR , 1'b1, 2'd0, 12'h04C, 32'd7     , 32'h0  , 4'd0 },
      '{OP_RD , 1'b1, 2'd0, 12'h044, 32'd0     , 32'h7  , 4'd3 },  // R3 unmask
      '{OP_RD , 1'b1, 2'd2, 12'h044, 32'd0     , 32'h3FF, 4'd3 },  // R3 other cpu
      '{OP_IRQ, 1'b0, 2'd0, 12'h000, 32'd0     , 32'h1  , 4'd10},  // R10
      '{OP_WR , 1'b1, 2'd2, 12'h04C, 32'd7     , 32'h0  , 4'd0 },
      '{OP_RD , 1'b1, 2'd2, 12'h044, 32'd0     , 32'h7  , 4'd5 },  // R5 routed
      '{OP_WR , 1'b1, 2'd1, 12'h04C, 32'd7     , 32'h0  , 4'd0 },
      '{OP_RD , 1'b1, 2'd1, 12'h044, 32'd0     , 32'h3FF, 4'd5 },  // R5 not routed
      '{OP_IRQ, 1'b0, 2'd0, 12'h000, 32'd0     , 32'h5  , 4'd10},  // R10
      '{OP_SRC, 1'b0, 2'd0, 12'h000, 32'h1080  , 32'h0  , 4'd0 },
      '{OP_WR , 1'b0, 2'd0, 12'h130, 32'd1     , 32'h0  , 4'd0 },
      '{OP_WR , 1'b0, 2'd0, 12'h030, 32'd12    , 32'h0  , 4'd0 },
      '{OP_WR , 1'b1, 2'd0, 12'h04C, 32'd12    , 32'h0  , 4'd0 },
      '{OP_RD , 1'b1, 2'd0, 12'h044, 32'd0     , 32'h7  , 4'd4 },  // R4 lowest wins
      '{OP_WR , 1'b0, 2'd0, 12'h034, 32'd7     , 32'h0  , 4'd0 },
      '{OP_RD , 1'b1, 2'd0, 12'h044, 32'd0     , 32'hC  , 4'd2 },  // R2 clear
      '{OP_RD , 1'b1, 2'd2, 12'h044, 32'd0     , 32'h3FF, 4'd2 },  // R2
      '{OP_WR , 1'b0, 2'd0, 12'h030, 32'd39    , 32'h0  , 4'd0 },
      '{OP_RD , 1'b1, 2'd2, 12'h044, 32'd0     , 32'h3FF, 4'd11},  // R11 no alias to 7
      '{OP_RD , 1'b1, 2'd0, 12'h044, 32'd0     , 32'hC  , 4'd11},  // R11
      '{OP_WR , 1'b1, 2'd0, 12'h048, 32'd44    , 32'h0  , 4'd0 },
      '{OP_RD , 1'b1, 2'd0, 12'h044, 32'd0     , 32'hC  , 4'd11},  // R11 no alias to 12
      '{OP_SRC, 1'b0, 2'd0, 12'h000, 32'h80    , 32'h0  , 4'd0 },
      '{OP_RD , 1'b1, 2'd0, 12'h044, 32'd0     , 32'h3FF, 4'd9 },  // R9 line low
      '{OP_IRQ, 1'b0, 2'd0, 12'h000, 32'd0     , 32'h0  , 4'd9 },  // R9
      '{OP_SRC, 1'b0, 2'd0, 12'h000, 32'h1000  , 32'h0  , 4'd0 },
      '{OP_RD , 1'b1, 2'd0, 12'h044, 32'd0     , 32'hC  , 4'd9 },  // R9 line high again
      '{OP_WR , 1'b1, 2'd0, 12'h048, 32'd12    , 32'h0  , 4'd0 },
      '{OP_RD , 1'b1, 2'd0, 12'h044, 32'd0     , 32'h3FF, 4'd3 },  // R3 mask
      '{OP_LOC, 1'b0, 2'd0, 12'h000, 32'h002   , 32'h0  , 4'd0 },
      '{OP_WR , 1'b1, 2'd1, 12'h04C, 32'd0     , 32'h0  , 4'd0 },
      '{OP_WR , 1'b1, 2'd0, 12'h04C, 32'd0     , 32'h0  , 4'd0 },
      '{OP_RD , 1'b1, 2'd1, 12'h044, 32'd0     , 32'h0  , 4'd7 },  // R7 doorbell
      '{OP_RD , 1'b1, 2'd0, 12'h044, 32'd0     , 32'h3FF, 4'd7 },  // R7 only that cpu
      '{OP_IRQ, 1'b0, 2'd0, 12'h000, 32'd0     , 32'h2  , 4'd7 },  // R7
      '{OP_LOC, 1'b0, 2'd0, 12'h000, 32'h080   , 32'h0  , 4'd0 },
      '{OP_WR , 1'b1, 2'd3, 12'h04C, 32'd1     , 32'h0  , 4'd0 },
      '{OP_RD , 1'b1, 2'd3, 12'h044, 32'd0     , 32'h1  , 4'd7 },  // R7 message
      '{OP_RD , 1'b1, 2'd1, 12'h044, 32'd0     , 32'h3FF, 4'd7 },  // R7 doorbell gone
      '{OP_LOC, 1'b0, 2'd0, 12'h000, 32'h400   , 32'h0  , 4'd0 },
      '{OP_WR , 1'b1, 2'd2, 12'h04C, 32'd5     , 32'h0  , 4'd0 },
      '{OP_SRC, 1'b0, 2'd0, 12'h000, 32'h1020  , 32'h0  , 4'd0 },
      '{OP_WR , 1'b1, 2'd0, 12'h04C, 32'd5     , 32'h0  , 4'd0 },
      '{OP_RD , 1'b1, 2'd2, 12'h044, 32'd0     , 32'h5  , 4'd8 },  // R8 timer
      '{OP_RD , 1'b1, 2'd0, 12'h044, 32'd0     , 32'h3FF, 4'd8 }   // R8 shared line ignored
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0;
   logic          bus_bank = 1'b0;
   logic [1:0]    bus_cpu = '0;
   logic [AW-1:0] bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [NS-1:0] src_line = '0;
   logic [NC-1:0] ipi_sum = '0;
   logic [NC-1:0] msg_sum = '0;
   logic [NC-1:0] tmr_line = '0;
   logic [NC-1:0] irq_out;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   irt_router #(.NUM_SRC(NS), .NUM_CPU(NC), .ADDR_W(AW)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_bank(bus_bank),
      .bus_cpu(bus_cpu), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .src_line(src_line), .ipi_sum(ipi_sum),
      .msg_sum(msg_sum), .tmr_line(tmr_line), .irq_out(irq_out));

   task automatic check(input logic [31:0] act, input logic [31:0] exp, input int req);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL R%0d: got 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic apply(input vec_t v);
      @(negedge clk);
      case (v.op)
         OP_WR: begin
            bus_bank = v.bank; bus_cpu = v.cpu; bus_addr = v.addr;
            bus_wdata = v.data; bus_wr = 1'b1;
            @(negedge clk);
            bus_wr = 1'b0;
         end
         OP_RD: begin
            bus_bank = v.bank; bus_cpu = v.cpu; bus_addr = v.addr;
            #1 check(bus_rdata, v.exp, int'(v.req));
         end
         OP_SRC: src_line = v.data[NS-1:0];
         OP_LOC: begin
            ipi_sum = v.data[3:0]; msg_sum = v.data[7:4]; tmr_line = v.data[11:8];
         end
         default: #1 check({28'd0, irq_out}, v.exp, int'(v.req));
      endcase
   endtask

   task automatic rd_ack(input int cpu, input logic [31:0] exp, input int req);
      vec_t v;
      v = '{OP_RD, 1'b1, 2'(cpu), 12'h044, 32'd0, exp, 4'(req)};
      apply(v);
   endtask

   task automatic wr(input logic bank, input int cpu, input int addr, input int data);
      vec_t v;
      v = '{OP_WR, bank, 2'(cpu), 12'(addr), 32'(data), 32'd0, 4'd0};
      apply(v);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < NV; i++) apply(VECS[i]);

      // R1: reset in mid-run, with the cpu2 timer line still high
      @(negedge clk); rst_n = 1'b0;
      repeat (2) @(negedge clk); rst_n = 1'b1;
      for (int c = 0; c < NC; c++) rd_ack(c, 32'h3FF, 1);   // R1
      #1 check({28'd0, irq_out}, 32'h0, 1);                 // R1
      @(negedge clk); bus_bank = 1'b0; bus_addr = 12'h11C;
      #1 check(bus_rdata, 32'h0, 1);                         // R1 routing cleared
      // R8: timer again after unmask, then R4 with doorbell below it
      wr(1'b1, 2, 'h04C, 5);
      rd_ack(2, 32'h5, 8);                                   // R8
      @(negedge clk); ipi_sum = 4'b0100;
      wr(1'b1, 2, 'h04C, 0);
      rd_ack(2, 32'h0, 4);                                   // R4 source 0 beats 5
      #1 check({28'd0, irq_out}, 32'h4, 10);                 // R10
      @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 5);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule